// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line-Break Detection

This block turns an asynchronous serial line into parallel characters. Its timing comes from a sample-clock enable, which stands for one rising edge of the receive clock. It counts 1, 16 or 64 such samples per bit. Once a falling edge has shown a start bit, it checks that bit again half a bit time later, then samples each bit at its middle. It assembles 5 to 8 data bits, LSB first. It checks an optional parity bit and only the first stop bit. The result goes into a single holding register that has a ready flag.

The block keeps three sticky error flags: parity, framing and overrun. An error-clear strobe resets all three. A line that stays at space for a whole character, including its stop bit, is reported once, as an all-zero character with the framing flag set. A break-detect output is raised at the same time. The receiver does not look for a new start bit until the line has been sampled at mark again.

The receiver runs only while its enable is high and the carrier-detect input is low. All inputs are assumed to be synchronous to `clk`.

Top module: `async_rx_brk`

## Requirements
- R1: `cfg_rate` selects the samples per bit: 00 = 1, 01 = 16, 10 or 11 = 64. The line is looked at only in clock cycles where `samp_en` is high.
- R2: With 16 or 64 samples per bit, the first low sample begins a start bit only if the line is still low half a bit time later. If it is high by then, no character is produced and the search for a start bit continues.
- R3: The data bits are sampled one bit time apart, starting from the confirmed start-bit midpoint, LSB first. `cfg_len` sets the character length: 00 = 5 bits, 01 = 6, 10 = 7, 11 = 8. `rx_data` bits at or above the length read 0. When a character is delivered, `rx_ready` rises.
- R4: When `cfg_par_en` = 1, a parity bit follows the data. `cfg_par_odd` = 1 expects an odd number of ones across the data and parity bits; 0 expects an even number. A mismatch sets `err_parity`.
- R5: Only the first stop bit is sampled. A low stop bit sets `err_frame`. The search for a start bit resumes on the very next sample, so a space that continues after a bad stop bit is taken as the next start bit.
- R6: If the start bit, every data bit, the parity bit (if enabled) and the stop bit are all low, exactly one character of 0x00 is delivered. For that character `err_frame` = 1 and `err_parity` is not set. `brk_det` goes high at the same time. No further start search happens, and `brk_det` stays high, until a sample sees the line high.
- R7: If a character is delivered while `rx_ready` is still set and `rd_ack` is not high in the same cycle, `err_overrun` is set and `rx_data` takes the new character.
- R8: A one-cycle `err_clr` clears `err_parity`, `err_overrun` and `err_frame`. If a delivery in the same cycle sets a flag, that flag stays set.
- R9: The receiver is active when `rx_enable` = 1 and `carrier_n` = 0. While it is inactive, `rx_ready`, `err_overrun` and `brk_det` are 0 and nothing is received. After it becomes active, the first sample is ignored and the start search begins with the second sample.
- R10: `rd_ack` (one cycle) clears `rx_ready` unless a new character is delivered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | One-cycle pulse per rising receive-clock edge |
| line_in | input | 1 | Serial line, mark = 1 |
| rx_enable | input | 1 | Receiver enable |
| carrier_n | input | 1 | Carrier detect, active low |
| cfg_rate | input | 2 | Samples per bit selector |
| cfg_len | input | 2 | Character length selector |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_ack | input | 1 | Holding register read strobe |
| err_clr | input | 1 | Clear error flags strobe |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character waiting |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_frame | output | 1 | Sticky framing error |
| brk_det | output | 1 | Line break in progress |

## Verification
The embedded properties check, on every cycle, the flag rules of the holding register: the clearing by `err_clr`, `rd_ack` and deactivation, and that an overrun needs a waiting character. They also check that a delivery is a single-cycle pulse, that `brk_det` drops only on a sample that sees mark, and that a rising `brk_det` is followed by the framing flag.

Only the bench scenarios can show that characters are correct across every length, parity mode and rate. The same goes for false-start rejection at the half-bit point, re-arming from a space after a bad stop bit, a break yielding a single character, and the ignored first sample after enable.

// File: rtl/rxb_pkg.sv
// Shared types for the oversampling serial receiver.
// Assumes: character width is fixed at 8 holding bits.
package rxb_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_OFF,    // receiver inactive
        ST_WAKE,   // first sample after activation is discarded
        ST_HUNT,   // looking for a space on the line
        ST_START,  // waiting for half-bit confirmation
        ST_DATA,   // sampling data bits
        ST_PAR,    // sampling parity bit
        ST_STOP,   // sampling the first stop bit
        ST_BRK     // break reported, waiting for mark
    } rx_state_t;
endpackage

// File: rtl/rxb_pacer.sv
// Bit-time pacer: counts sample pulses and flags the half-bit and full-bit
// points. Assumes the caller clears it at the start edge and at the confirmed
// start midpoint. Rate 00 means one sample per bit (no half-bit point).
module rxb_pacer #(
    parameter int MID_FACTOR = 16,
    parameter int HI_FACTOR  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       clr,
    input  logic [1:0] rate,
    output logic       half_due,
    output logic       full_due
);
    localparam int CW = $clog2(HI_FACTOR);

    logic [CW-1:0] cnt;
    logic [CW-1:0] full_last;
    logic [CW-1:0] half_last;

    // Pick the terminal counts for the selected rate.
    always_comb begin
        unique case (rate)
            2'b00: begin
                full_last = '0;
                half_last = '0;
            end
            2'b01: begin
                full_last = CW'(MID_FACTOR - 1);
                half_last = CW'(MID_FACTOR / 2 - 1);
            end
            default: begin
                full_last = CW'(HI_FACTOR - 1);
                half_last = CW'(HI_FACTOR / 2 - 1);
            end
        endcase
    end

    assign half_due = tick && (rate != 2'b00) && (cnt == half_last);
    assign full_due = tick && (cnt == full_last);

    // Sample counter, wrapping at the end of each bit time.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= full_due ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rxb_framer.sv
// Character framer: start validation, data/parity/stop sampling, framing and
// break classification. Emits a one-cycle delivery pulse with the character
// and its error bits. Assumes line_in is synchronous to clk.
module rxb_framer
    import rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              line_in,
    input  logic              one_x,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              half_due,
    input  logic              full_due,
    output logic              pace_clr,
    output logic              dv,
    output logic [CHAR_W-1:0] dv_data,
    output logic              dv_perr,
    output logic              dv_ferr,
    output logic              brk_det
);
    rx_state_t         state;
    logic [2:0]        bit_idx;
    logic [2:0]        last_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_bit;
    logic              all_low;
    logic              par_bad;

    assign last_idx = 3'd4 + {1'b0, cfg_len};
    assign par_bad  = cfg_par_en && ((^shreg ^ par_bit) != cfg_par_odd);
    // Keep the pacer at zero outside timed states and at the start midpoint.
    assign pace_clr = (state != ST_START && state != ST_DATA &&
                       state != ST_PAR && state != ST_STOP) ||
                      (state == ST_START && half_due);

    // Receive state machine and character assembly.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state   <= ST_OFF;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            all_low <= 1'b0;
            dv      <= 1'b0;
            dv_data <= '0;
            dv_perr <= 1'b0;
            dv_ferr <= 1'b0;
            brk_det <= 1'b0;
        end else begin
            dv <= 1'b0;
            unique case (state)
                ST_OFF:  state <= ST_WAKE;
                ST_WAKE: if (tick) state <= ST_HUNT;
                ST_HUNT: if (tick && !line_in) begin
                    shreg   <= '0;
                    bit_idx <= '0;
                    par_bit <= 1'b0;
                    all_low <= 1'b1;
                    state   <= one_x ? ST_DATA : ST_START;
                end
                ST_START: if (half_due) state <= line_in ? ST_HUNT : ST_DATA;
                ST_DATA: if (full_due) begin
                    shreg[bit_idx] <= line_in;
                    all_low        <= all_low && !line_in;
                    if (bit_idx == last_idx) state <= cfg_par_en ? ST_PAR : ST_STOP;
                    else                     bit_idx <= bit_idx + 3'd1;
                end
                ST_PAR: if (full_due) begin
                    par_bit <= line_in;
                    all_low <= all_low && !line_in;
                    state   <= ST_STOP;
                end
                ST_STOP: if (full_due) begin
                    dv <= 1'b1;
                    if (!line_in && all_low) begin
                        dv_data <= '0;
                        dv_perr <= 1'b0;
                        dv_ferr <= 1'b1;
                        brk_det <= 1'b1;
                        state   <= ST_BRK;
                    end else begin
                        dv_data <= shreg;
                        dv_perr <= par_bad;
                        dv_ferr <= !line_in;
                        state   <= ST_HUNT;
                    end
                end
                ST_BRK: if (tick && line_in) begin
                    brk_det <= 1'b0;
                    state   <= ST_HUNT;
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // R3: a delivery is a single-cycle pulse.
    p_single_dv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dv |=> !dv);

    // R6: break indication ends only on a sample that sees mark.
    p_brk_ends_on_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(brk_det) && $past(active)) |-> ($past(tick) && $past(line_in)));
endmodule

// File: rtl/rxb_hold.sv
// Holding register with ready and sticky error flags. Assumes the delivery
// pulse is one cycle wide; deactivation clears ready and overrun.
module rxb_hold
    import rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              dv,
    input  logic [CHAR_W-1:0] dv_data,
    input  logic              dv_perr,
    input  logic              dv_ferr,
    input  logic              rd_ack,
    input  logic              err_clr,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_frame
);
    // Ready and overrun tracking, cleared while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            rx_ready    <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (dv)          rx_ready <= 1'b1;
            else if (rd_ack) rx_ready <= 1'b0;
            if (dv && rx_ready && !rd_ack) err_overrun <= 1'b1;
            else if (err_clr)              err_overrun <= 1'b0;
        end
    end

    // Character capture and sticky parity/framing flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
        end else begin
            if (dv) rx_data <= dv_data;
            if (dv && dv_perr) err_parity <= 1'b1;
            else if (err_clr)  err_parity <= 1'b0;
            if (dv && dv_ferr) err_frame <= 1'b1;
            else if (err_clr)  err_frame <= 1'b0;
        end
    end

    // R7: overrun can only appear while a character was waiting.
    p_ovr_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(rx_ready));

    // R8: a clear with no delivery leaves all error flags low.
    p_clear_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !dv) |=> (!err_parity && !err_overrun && !err_frame));

    // R9: an inactive receiver holds nothing.
    p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!rx_ready && !err_overrun));

    // R10: a read with no delivery empties the register.
    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !dv) |=> !rx_ready);
endmodule

// File: rtl/async_rx_brk.sv
// Oversampling asynchronous receiver with break detection. Wires the pacer,
// framer and holding register. Assumes all inputs are synchronous to clk and
// samp_en marks each rising receive-clock edge.
module async_rx_brk
    import rxb_pkg::*;
#(
    parameter int MID_FACTOR = 16,
    parameter int HI_FACTOR  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic              line_in,
    input  logic              rx_enable,
    input  logic              carrier_n,
    input  logic [1:0]        cfg_rate,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rd_ack,
    input  logic              err_clr,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              brk_det
);
    logic              active;
    logic              half_due, full_due, pace_clr;
    logic              dv, dv_perr, dv_ferr;
    logic [CHAR_W-1:0] dv_data;

    assign active = rx_enable && !carrier_n;

    rxb_pacer #(.MID_FACTOR(MID_FACTOR), .HI_FACTOR(HI_FACTOR)) u_pacer (
        .clk(clk), .rst_n(rst_n), .tick(samp_en), .clr(pace_clr),
        .rate(cfg_rate), .half_due(half_due), .full_due(full_due)
    );

    rxb_framer u_framer (
        .clk(clk), .rst_n(rst_n), .active(active), .tick(samp_en),
        .line_in(line_in), .one_x(cfg_rate == 2'b00), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .half_due(half_due), .full_due(full_due), .pace_clr(pace_clr),
        .dv(dv), .dv_data(dv_data), .dv_perr(dv_perr), .dv_ferr(dv_ferr),
        .brk_det(brk_det)
    );

    rxb_hold u_hold (
        .clk(clk), .rst_n(rst_n), .active(active), .dv(dv),
        .dv_data(dv_data), .dv_perr(dv_perr), .dv_ferr(dv_ferr),
        .rd_ack(rd_ack), .err_clr(err_clr), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_parity(err_parity),
        .err_overrun(err_overrun), .err_frame(err_frame)
    );

    // R6: a reported break always carries a framing error.
    p_brk_has_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_det) |=> err_frame);
endmodule

// File: tb/async_rx_brk_bench.sv
module async_rx_brk_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_en = 1'b0;
    logic       line_in = 1'b1;
    logic       rx_enable = 1'b0;
    logic       carrier_n = 1'b0;
    logic [1:0] cfg_rate = 2'b00;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_ack = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_overrun, err_frame, brk_det;

    int n_chk = 0;
    int n_err = 0;
    int fac = 1;

    always #2.5 clk = ~clk;

    async_rx_brk u_async_rx_brk (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .line_in(line_in),
        .rx_enable(rx_enable), .carrier_n(carrier_n), .cfg_rate(cfg_rate),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_ack(rd_ack), .err_clr(err_clr), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_parity(err_parity),
        .err_overrun(err_overrun), .err_frame(err_frame), .brk_det(brk_det)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One sample: line value and sample pulse presented together.
    task automatic tick_line(input logic v);
        line_in = v;
        samp_en = 1'b1;
        @(negedge clk) samp_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        repeat (fac) tick_line(v);
    endtask

    task automatic set_rate(input logic [1:0] r);
        cfg_rate = r;
        fac = (r == 2'b00) ? 1 : (r == 2'b01) ? 16 : 64;
    endtask

    // pm: 0 none, 1 even, 2 odd
    task automatic send_frame(input logic [7:0] d, input int nb, input int pm,
                              input bit flip, input logic stopv);
        logic p;
        p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= d[i];
        if (pm == 2) p = ~p;
        if (flip) p = ~p;
        repeat (2) tick_line(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (pm != 0) send_bit(p);
        send_bit(stopv);
        send_bit(1'b1);
    endtask

    task automatic pulse_rd();
        rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_good(input logic [7:0] exp);
        chk(rx_ready == 1'b1, "R3 ready after frame", rx_ready, 1);
        chk(rx_data == exp, "R3 data", rx_data, exp);
        chk(err_parity == 1'b0, "R4 no parity error", err_parity, 0);
        chk(err_frame == 1'b0, "R5 no framing error", err_frame, 0);
        pulse_rd();
        chk(rx_ready == 1'b0, "R10 read clears ready", rx_ready, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all R): actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        logic [7:0] m;
        pats[0] = 8'h5A; pats[1] = 8'hA5; pats[2] = 8'hFF; pats[3] = 8'h13;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_ready == 1'b0 && brk_det == 1'b0, "R9 reset ready/brk", {rx_ready, brk_det}, 0);
        chk({err_parity, err_overrun, err_frame} == 3'b000, "R9 reset flags",
            {err_parity, err_overrun, err_frame}, 0);

        // R9: first sample after enable is ignored.
        set_rate(2'b00);
        rx_enable = 1'b1;
        @(negedge clk);
        tick_line(1'b0);
        repeat (12) tick_line(1'b1);
        chk(rx_ready == 1'b0, "R9 first sample ignored", rx_ready, 0);

        // R9: carrier absent blocks reception.
        carrier_n = 1'b1;
        send_frame(8'h3C, 8, 0, 1'b0, 1'b1);
        chk(rx_ready == 1'b0, "R9 no carrier no data", rx_ready, 0);
        carrier_n = 1'b0;
        @(negedge clk);

        // R1 R3 R4 R5: sweep rate, length, parity and patterns.
        for (int r = 0; r < 2; r++) begin
            set_rate(2'(r));
            for (int l = 0; l < 4; l++) begin
                cfg_len = 2'(l);
                m = 8'((1 << (5 + l)) - 1);
                for (int pm = 0; pm < 3; pm++) begin
                    cfg_par_en  = (pm != 0);
                    cfg_par_odd = (pm == 2);
                    for (int k = 0; k < 4; k++) begin
                        send_frame(pats[k], 5 + l, pm, 1'b0, 1'b1);
                        read_good(pats[k] & m);
                    end
                end
            end
        end

        // R1: 64 samples per bit.
        set_rate(2'b10);
        cfg_len = 2'b11; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        send_frame(8'hC6, 8, 2, 1'b0, 1'b1);
        read_good(8'hC6);

        // R4 R8: parity mismatch, then clear.
        set_rate(2'b01);
        cfg_par_odd = 1'b0;
        send_frame(8'h71, 8, 1, 1'b1, 1'b1);
        chk(err_parity == 1'b1, "R4 parity error set", err_parity, 1);
        chk(rx_data == 8'h71, "R4 data with parity error", rx_data, 8'h71);
        pulse_rd();
        pulse_clr();
        chk(err_parity == 1'b0, "R8 clear parity", err_parity, 0);
        cfg_par_en = 1'b0;

        // R2: false start rejected, then a normal frame is received.
        repeat (2) tick_line(1'b1);
        repeat (4) tick_line(1'b0);
        repeat (3) send_bit(1'b1);
        chk(rx_ready == 1'b0, "R2 false start ignored", rx_ready, 0);
        send_frame(8'hC3, 8, 0, 1'b0, 1'b1);
        chk(rx_ready == 1'b1 && rx_data == 8'hC3, "R2 frame after false start", rx_data, 8'hC3);
        pulse_rd();

        // R5: missing stop bit.
        send_frame(8'h3C, 8, 0, 1'b0, 1'b0);
        chk(err_frame == 1'b1, "R5 framing error", err_frame, 1);
        chk(rx_ready == 1'b1 && rx_data == 8'h3C, "R5 data kept", rx_data, 8'h3C);
        chk(brk_det == 1'b0, "R6 no break on plain framing error", brk_det, 0);
        pulse_rd();
        pulse_clr();
        chk(err_frame == 1'b0, "R8 clear framing", err_frame, 0);

        // R5 R7: space after bad stop starts the next character; overrun.
        set_rate(2'b00);
        repeat (2) tick_line(1'b1);
        tick_line(1'b0);
        for (int i = 0; i < 8; i++) tick_line(pats[1][i] ^ 1'b1);
        tick_line(1'b0);
        tick_line(1'b0);
        for (int i = 0; i < 8; i++) tick_line(pats[3][i]);
        tick_line(1'b1);
        repeat (2) tick_line(1'b1);
        chk(rx_data == pats[3], "R5 re-arm from space", rx_data, pats[3]);
        chk(err_overrun == 1'b1, "R7 overrun set", err_overrun, 1);
        chk(err_frame == 1'b1, "R5 framing from first char", err_frame, 1);

        // R9: disable clears ready and overrun.
        rx_enable = 1'b0;
        repeat (2) @(negedge clk);
        chk(rx_ready == 1'b0 && err_overrun == 1'b0, "R9 disable clears",
            {rx_ready, err_overrun}, 0);
        pulse_clr();
        chk(err_frame == 1'b0, "R8 clear after disable", err_frame, 0);
        rx_enable = 1'b1;
        @(negedge clk);

        // R6: line break at 16 samples per bit.
        set_rate(2'b01);
        repeat (2) tick_line(1'b1);
        repeat (12) send_bit(1'b0);
        chk(rx_ready == 1'b1 && rx_data == 8'h00, "R6 break char", rx_data, 0);
        chk(err_frame == 1'b1 && err_parity == 1'b0, "R6 break flags",
            {err_parity, err_frame}, 1);
        chk(brk_det == 1'b1, "R6 break detect high", brk_det, 1);
        pulse_rd();
        repeat (24) send_bit(1'b0);
        chk(rx_ready == 1'b0, "R6 single break char", rx_ready, 0);
        chk(brk_det == 1'b1, "R6 break held while low", brk_det, 1);
        tick_line(1'b1);
        chk(brk_det == 1'b0, "R6 break ends on mark", brk_det, 0);
        pulse_clr();
        send_frame(8'h96, 8, 0, 1'b0, 1'b1);
        read_good(8'h96);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule